// File: doc/BRIEF.md
# Variable-length instruction decode stage

This block is one pipeline register stage that breaks a 16-bit instruction word into the fields a later execute stage needs. The two top bits select one of three layouts: a register-register layout with an 8-bit opcode, a register-plus-small-constant layout with a 2-bit sub-opcode, and a conditional branch layout with a 4-bit condition. For each accepted word the stage reports the layout, the operation code, two register indices, an 8-bit constant, whether a 32-bit extension word follows (so the instruction is 6 bytes instead of 2), the size and direction of any memory access, whether loaded data is zero-extended, and an illegal-encoding flag.

A word is presented with `in_valid` high. Its decode appears on the outputs one clock later with `out_valid` high, and stays there until the next accepted word. An illegal word hides every other field: the outputs read zero, except for the length, which reads 2 bytes.

Top module: `ifd_decode_stage`

## Requirements
- R1: The layout is taken from the top bits: bit 15 = 0 gives `out_form` = 1; bits [15:14] = 2'b10 give `out_form` = 2; bits [15:14] = 2'b11 give `out_form` = 3.
- R2: In layout 1, `out_op` = bits [15:8], `out_ra` = bits [7:4], `out_rb` = bits [3:0], and `out_imm` = 0.
- R3: In layout 2, `out_op` = bits [13:12], zero-extended, where 0 is increment, 1 is decrement, 2 is read special register and 3 is write special register. `out_ra` = bits [11:8], `out_rb` = 0, and `out_imm` = bits [7:0]. Every layout 2 word is legal.
- R4: In layout 3, `out_op` = the condition in bits [13:10], zero-extended, and `out_ra`, `out_rb` and `out_imm` are 0. Conditions 0 to 9 are legal.
- R5: `out_ext` = 1 and `out_len` = 6 for layout 1 opcodes 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30 and 0x36 to 0x39. Every other legal word gives `out_ext` = 0 and `out_len` = 2.
- R6: `out_illegal` = 1 for layout 1 opcodes 0x0F to 0x18 and 0x3A to 0x7F, and for layout 3 conditions 10 to 15. It is 0 for every other word.
- R7: When `out_illegal` = 1, `out_len` = 2 and all other outputs (`out_form`, `out_op`, `out_ra`, `out_rb`, `out_imm`, `out_ext`, `out_mem_size`, `out_store`, `out_zext`) are 0.
- R8: `out_mem_size` is one-hot, with bit0 = byte, bit1 = halfword and bit2 = word, and `out_store` gives the direction (1 = store):
  - word stores: 0x06, 0x09, 0x0B, 0x0D;
  - word loads: 0x07, 0x08, 0x0A, 0x0C;
  - byte stores: 0x1E, 0x1F, 0x37;
  - byte loads: 0x1C, 0x1D, 0x36;
  - halfword stores: 0x23, 0x24, 0x39;
  - halfword loads: 0x21, 0x22, 0x38.

  Every other word gives `out_mem_size` = 0 and `out_store` = 0.
- R9: `out_zext` = 1 exactly for byte and halfword loads.
- R10: The outputs update on the rising edge at which `in_valid` = 1. `out_valid` is `in_valid` delayed by one clock. While `in_valid` = 0, the decoded fields hold their values.
- R11: While `rst_n` = 0 (asynchronous, active low), all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | `in_word` is to be decoded this cycle |
| in_word | input | 16 | Instruction word |
| out_valid | output | 1 | Decoded fields are for a newly accepted word |
| out_form | output | 2 | Layout 1, 2 or 3 (0 when illegal) |
| out_op | output | 8 | Opcode, sub-opcode or condition |
| out_ra | output | 4 | Register field A |
| out_rb | output | 4 | Register field B |
| out_imm | output | 8 | Short unsigned constant (layout 2) |
| out_ext | output | 1 | A 32-bit extension word follows |
| out_len | output | 3 | Instruction length in bytes (2 or 6) |
| out_mem_size | output | 3 | One-hot access size: byte, half, word |
| out_store | output | 1 | Memory access is a store |
| out_zext | output | 1 | Loaded data is zero-extended |
| out_illegal | output | 1 | Illegal encoding |

## Verification
All state sits in one register, so a wrong captured decode shows at the ports in the very cycle after the word is accepted. A fault in the legality or length rule shows as a wrong `out_len` or `out_illegal`. A fault in the opcode grouping shows as a wrong size, direction or zero-extend flag. The stimulus table therefore holds the codes just inside and just outside each legal opcode range and each condition range, next to one member of every memory group. Failing to hold the fields while `in_valid` is low shows on the next idle cycle, when the bench compares the outputs against the previous decode.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
  localparam int WORD_W = 16;
  localparam int OP_W   = 8;
  localparam int REG_W  = 4;
  localparam int IMM_W  = 8;
  localparam int LEN_W  = 3;

  typedef enum logic [1:0] {
    FORM_NONE  = 2'd0,
    FORM_ONE   = 2'd1,
    FORM_TWO   = 2'd2,
    FORM_THREE = 2'd3
  } form_e;

  typedef enum logic [2:0] {
    MSZ_NONE = 3'b000,
    MSZ_BYTE = 3'b001,
    MSZ_HALF = 3'b010,
    MSZ_WORD = 3'b100
  } msz_e;

  typedef struct packed {
    form_e              form;
    logic [OP_W-1:0]    op;
    logic [REG_W-1:0]   ra;
    logic [REG_W-1:0]   rb;
    logic [IMM_W-1:0]   imm;
    logic               ext;
    logic [LEN_W-1:0]   len;
    msz_e               msz;
    logic               store;
    logic               zext;
    logic               illegal;
  } dec_t;

  // Layout 1 opcode is defined
  function automatic logic f1_legal(input logic [OP_W-1:0] op);
    return op inside {[8'h00:8'h0E], [8'h19:8'h39]};
  endfunction

  // Layout 1 opcode carries a trailing 32-bit word
  function automatic logic f1_ext(input logic [OP_W-1:0] op);
    return op inside {8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D, 8'h1A,
                      8'h1B, 8'h1D, 8'h1F, 8'h20, 8'h22, 8'h24, 8'h30,
                      [8'h36:8'h39]};
  endfunction

  // Access size of a layout 1 memory opcode
  function automatic msz_e f1_msz(input logic [OP_W-1:0] op);
    msz_e s;
    case (op)
      8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D: s = MSZ_WORD;
      8'h1C, 8'h1D, 8'h1E, 8'h1F, 8'h36, 8'h37:               s = MSZ_BYTE;
      8'h21, 8'h22, 8'h23, 8'h24, 8'h38, 8'h39:               s = MSZ_HALF;
      default:                                                s = MSZ_NONE;
    endcase
    return s;
  endfunction

  // Direction of a layout 1 memory opcode
  function automatic logic f1_store(input logic [OP_W-1:0] op);
    return op inside {8'h06, 8'h09, 8'h0B, 8'h0D, 8'h1E, 8'h1F, 8'h37,
                      8'h23, 8'h24, 8'h39};
  endfunction
endpackage

// File: rtl/ifd_form_sel.sv
module ifd_form_sel
  import ifd_pkg::*;
#(
  parameter int MAX_COND = 9
) (
  input  logic [WORD_W-1:0] word,
  output form_e             form,
  output logic [OP_W-1:0]   op,
  output logic [REG_W-1:0]  ra,
  output logic [REG_W-1:0]  rb,
  output logic [IMM_W-1:0]  imm,
  output logic              cond_bad
);
  always_comb begin
    form     = FORM_ONE;
    op       = '0;
    ra       = '0;
    rb       = '0;
    imm      = '0;
    cond_bad = 1'b0;
    if (!word[15]) begin
      form = FORM_ONE;
      op   = word[15:8];
      ra   = word[7:4];
      rb   = word[3:0];
    end else if (!word[14]) begin
      form = FORM_TWO;
      op   = {6'b0, word[13:12]};
      ra   = word[11:8];
      imm  = word[7:0];
    end else begin
      form     = FORM_THREE;
      op       = {4'b0, word[13:10]};
      cond_bad = word[13:10] > 4'(MAX_COND);
    end
  end
endmodule

// File: rtl/ifd_f1_attr.sv
module ifd_f1_attr
  import ifd_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output logic            legal,
  output logic            ext,
  output msz_e            msz,
  output logic            store
);
  always_comb begin
    legal = f1_legal(op);
    ext   = f1_ext(op);
    msz   = f1_msz(op);
    store = f1_store(op);
  end
endmodule

// File: rtl/ifd_decode_stage.sv
module ifd_decode_stage
  import ifd_pkg::*;
#(
  parameter int MAX_COND  = 9,
  parameter int LEN_SHORT = 2,
  parameter int LEN_LONG  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic [1:0]        out_form,
  output logic [OP_W-1:0]   out_op,
  output logic [REG_W-1:0]  out_ra,
  output logic [REG_W-1:0]  out_rb,
  output logic [IMM_W-1:0]  out_imm,
  output logic              out_ext,
  output logic [LEN_W-1:0]  out_len,
  output logic [2:0]        out_mem_size,
  output logic              out_store,
  output logic              out_zext,
  output logic              out_illegal
);
  localparam logic [LEN_W-1:0] LS = LEN_W'(LEN_SHORT);
  localparam logic [LEN_W-1:0] LL = LEN_W'(LEN_LONG);

  form_e              raw_form;
  logic [OP_W-1:0]    raw_op;
  logic [REG_W-1:0]   raw_ra, raw_rb;
  logic [IMM_W-1:0]   raw_imm;
  logic               f3_illegal;
  logic               f1_ok, f1_long, f1_st;
  msz_e               f1_size;
  logic               f1_illegal;
  logic               dec_illegal;
  dec_t               nxt, q;
  logic               valid_q;

  ifd_form_sel #(.MAX_COND(MAX_COND)) u_sel (
    .word(in_word), .form(raw_form), .op(raw_op), .ra(raw_ra),
    .rb(raw_rb), .imm(raw_imm), .cond_bad(f3_illegal)
  );

  ifd_f1_attr u_attr (
    .op(raw_op), .legal(f1_ok), .ext(f1_long), .msz(f1_size), .store(f1_st)
  );

  assign f1_illegal  = (raw_form == FORM_ONE) && !f1_ok;
  assign dec_illegal = f1_illegal || f3_illegal;

  always_comb begin
    nxt     = '0;
    nxt.len = LS;
    if (dec_illegal) begin
      nxt.illegal = 1'b1;
    end else begin
      nxt.form = raw_form;
      nxt.op   = raw_op;
      nxt.ra   = raw_ra;
      nxt.rb   = raw_rb;
      nxt.imm  = raw_imm;
      if (raw_form == FORM_ONE) begin
        nxt.ext   = f1_long;
        nxt.len   = f1_long ? LL : LS;
        nxt.msz   = f1_size;
        nxt.store = f1_st;
        nxt.zext  = !f1_st && (f1_size == MSZ_BYTE || f1_size == MSZ_HALF);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) q <= nxt;
    end
  end

  assign out_valid    = valid_q;
  assign out_form     = q.form;
  assign out_op       = q.op;
  assign out_ra       = q.ra;
  assign out_rb       = q.rb;
  assign out_imm      = q.imm;
  assign out_ext      = q.ext;
  assign out_len      = q.len;
  assign out_mem_size = q.msz;
  assign out_store    = q.store;
  assign out_zext     = q.zext;
  assign out_illegal  = q.illegal;

  // R7
  illegal_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (out_len == LS && out_form == 2'd0 && !out_ext &&
                     out_mem_size == 3'b000 && !out_store));
  // R5
  ext_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal) |-> (out_len == (out_ext ? LL : LS)));
  // R8
  msz_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_mem_size));
  // R9
  zext_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_zext |-> (!out_store && (out_mem_size == 3'b001 || out_mem_size == 3'b010)));
  // R10
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_op) && $stable(out_form) && $stable(out_len)));
  // R4
  branch_noregs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_form == 2'd3) |-> (out_ra == '0 && out_rb == '0 && out_imm == '0));
endmodule

// File: tb/sim_ifd_decode_stage.sv
module sim_ifd_decode_stage;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 26;

  // {word16, form2, op8, ra4, rb4, imm8, ext1, len3, msz3, st1, zx1, ill1}
  localparam logic [51:0] VEC [NV] = '{
    {16'h0000, 2'd1, 8'h00, 4'h0, 4'h0, 8'h00, 1'b0, 3'd2, 3'b000, 1'b0, 1'b0, 1'b0},
    {16'h0130, 2'd1, 8'h01, 4'h3, 4'h0, 8'h00, 1'b1, 3'd6, 3'b000, 1'b0, 1'b0, 1'b0},
    {16'h0A5C, 2'd1, 8'h0A, 4'h5, 4'hC, 8'h00, 1'b0, 3'd2, 3'b100, 1'b0, 1'b0, 1'b0},
    {16'h0B21, 2'd1, 8'h0B, 4'h2, 4'h1, 8'h00, 1'b0, 3'd2, 3'b100, 1'b1, 1'b0, 1'b0},
    {16'h1C47, 2'd1, 8'h1C, 4'h4, 4'h7, 8'h00, 1'b0, 3'd2, 3'b001, 1'b0, 1'b1, 1'b0},
    {16'h2189, 2'd1, 8'h21, 4'h8, 4'h9, 8'h00, 1'b0, 3'd2, 3'b010, 1'b0, 1'b1, 1'b0},
    {16'h3712, 2'd1, 8'h37, 4'h1, 4'h2, 8'h00, 1'b1, 3'd6, 3'b001, 1'b1, 1'b0, 1'b0},
    {16'h38AB, 2'd1, 8'h38, 4'hA, 4'hB, 8'h00, 1'b1, 3'd6, 3'b010, 1'b0, 1'b1, 1'b0},
    {16'h0F00, 2'd0, 8'h00, 4'h0, 4'h0, 8'h00, 1'b0, 3'd2, 3'b000, 1'b0, 1'b0, 1'b1},
    {16'h1800, 2'd0, 8'h00, 4'h0, 4'h0, 8'h00, 1'b0, 3'd2, 3'b000, 1'b0, 1'b0, 1'b1},
    {16'h3A00, 2'd0, 8'h00, 4'h0, 4'h0, 8'h00, 1'b0, 3'd2, 3'b000, 1'b0, 1'b0, 1'b1},
    {16'h7F12, 2'd0, 8'h00, 4'h0, 4'h0, 8'h00, 1'b0, 3'd2, 3'b000, 1'b0, 1'b0, 1'b1},
    {16'h0E12, 2'd1, 8'h0E, 4'h1, 4'h2, 8'h00, 1'b0, 3'd2, 3'b000, 1'b0, 1'b0, 1'b0},
    {16'h1900, 2'd1, 8'h19, 4'h0, 4'h0, 8'h00, 1'b0, 3'd2, 3'b000, 1'b0, 1'b0, 1'b0},
    {16'h3000, 2'd1, 8'h30, 4'h0, 4'h0, 8'h00, 1'b1, 3'd6, 3'b000, 1'b0, 1'b0, 1'b0},
    {16'h0607, 2'd1, 8'h06, 4'h0, 4'h7, 8'h00, 1'b0, 3'd2, 3'b100, 1'b1, 1'b0, 1'b0},
    {16'h1F50, 2'd1, 8'h1F, 4'h5, 4'h0, 8'h00, 1'b1, 3'd6, 3'b001, 1'b1, 1'b0, 1'b0},
    {16'h8A7F, 2'd2, 8'h00, 4'hA, 4'h0, 8'h7F, 1'b0, 3'd2, 3'b000, 1'b0, 1'b0, 1'b0},
    {16'h9500, 2'd2, 8'h01, 4'h5, 4'h0, 8'h00, 1'b0, 3'd2, 3'b000, 1'b0, 1'b0, 1'b0},
    {16'hA244, 2'd2, 8'h02, 4'h2, 4'h0, 8'h44, 1'b0, 3'd2, 3'b000, 1'b0, 1'b0, 1'b0},
    {16'hB3FE, 2'd2, 8'h03, 4'h3, 4'h0, 8'hFE, 1'b0, 3'd2, 3'b000, 1'b0, 1'b0, 1'b0},
    {16'hC000, 2'd3, 8'h00, 4'h0, 4'h0, 8'h00, 1'b0, 3'd2, 3'b000, 1'b0, 1'b0, 1'b0},
    {16'hC7FF, 2'd3, 8'h01, 4'h0, 4'h0, 8'h00, 1'b0, 3'd2, 3'b000, 1'b0, 1'b0, 1'b0},
    {16'hE400, 2'd3, 8'h09, 4'h0, 4'h0, 8'h00, 1'b0, 3'd2, 3'b000, 1'b0, 1'b0, 1'b0},
    {16'hE800, 2'd0, 8'h00, 4'h0, 4'h0, 8'h00, 1'b0, 3'd2, 3'b000, 1'b0, 1'b0, 1'b1},
    {16'hFC00, 2'd0, 8'h00, 4'h0, 4'h0, 8'h00, 1'b0, 3'd2, 3'b000, 1'b0, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_word = '0;
  logic        out_valid;
  logic [1:0]  out_form;
  logic [7:0]  out_op;
  logic [3:0]  out_ra, out_rb;
  logic [7:0]  out_imm;
  logic        out_ext;
  logic [2:0]  out_len;
  logic [2:0]  out_mem_size;
  logic        out_store, out_zext, out_illegal;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifd_decode_stage u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_form(out_form), .out_op(out_op),
    .out_ra(out_ra), .out_rb(out_rb), .out_imm(out_imm), .out_ext(out_ext),
    .out_len(out_len), .out_mem_size(out_mem_size), .out_store(out_store),
    .out_zext(out_zext), .out_illegal(out_illegal)
  );

  function automatic logic [35:0] actual();
    return {out_form, out_op, out_ra, out_rb, out_imm, out_ext, out_len,
            out_mem_size, out_store, out_zext, out_illegal};
  endfunction

  function automatic string tag_of(input logic [35:0] e);
    if (e[0])            return "R1 R6 R7";
    if (e[5:3] != 3'b0)  return "R1 R8 R9";
    if (e[9])            return "R1 R5";
    if (e[35:34] == 2'd1) return "R1 R2 R5";
    if (e[35:34] == 2'd2) return "R1 R3";
    return "R1 R4";
  endfunction

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    logic [35:0] last;
    repeat (3) @(negedge clk);
    // R11: outputs zero during reset
    chk("R11 reset", {actual(), 1'b0}, {36'h0, out_valid});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 after reset", actual(), 36'h0);
    chk("R10 no valid", {35'h0, out_valid}, 36'h0);

    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      in_word  = VEC[i][51:36];
      @(negedge clk);
      chk("R10 valid out", {35'h0, out_valid}, 36'h1);
      chk(tag_of(VEC[i][35:0]), actual(), VEC[i][35:0]);
    end

    // R10: fields hold while in_valid is low
    last     = actual();
    in_valid = 1'b0;
    in_word  = 16'h0130;
    @(negedge clk);
    chk("R10 valid drops", {35'h0, out_valid}, 36'h0);
    chk("R10 hold", actual(), last);
    @(negedge clk);
    chk("R10 hold 2", actual(), last);

    // R10: one-cycle latency, capture on the accepting edge only
    in_valid = 1'b1;
    in_word  = 16'h0130;
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = 16'h0F00;
    chk("R5 R10 latency", actual(), VEC[1][35:0]);
    @(negedge clk);
    chk("R10 ignore idle word", actual(), VEC[1][35:0]);

    // R11: reset in mid-run clears outputs
    in_valid = 1'b1;
    in_word  = 16'h3712;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11 async reset", {actual(), out_valid}, 37'h0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule